// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of an 8-bit timer. On every enabled timer tick it takes exactly one step: it increments the count, decrements it, or clears it to zero. Which step it takes depends on the selected waveform mode and, in the symmetric mode, on a direction bit that the block flips by itself at the two ends of the range. The tick comes from a source-select stage. That stage forwards one of five prescaled strobes supplied from outside, or an edge of an external pin after a two-stage synchroniser. It can also select nothing, which freezes the counter.

A host bus can load the count in any cycle, whether a tick source is active or not, and the current count is always visible on an output. A host load always wins over a clear or count step in the same cycle. The block flags the minimum and maximum of the count. It also holds a sticky overflow flag that software or an interrupt acknowledge clears. The point at which that flag is set depends on the waveform mode.

Top module: `updn_tmr_core`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0 and the direction output is 0 (up).
- R2: The tick source is chosen by `clk_sel_i`. Code 0 selects nothing and the count holds. Codes 1 to 5 use `presc_tick_i[code-1]` (strobes for divide by 1, 8, 64, 256 and 1024), and the other strobe bits are ignored.
- R3: Code 6 counts once on each falling edge of `ext_pin_i` and code 7 counts once on each rising edge. The pin passes through two synchronising flip-flops and an edge register, and the opposite edge has no effect.
- R4: With `wave_mode_i` 0, or any code from 3 to 7 (wrap mode), each tick increments the count. The step from 0xFF to 0x00 sets the overflow flag.
- R5: With `wave_mode_i` 2 (clear-on-match), a tick while `cmp_match_a_i` is high clears the count to 0x00, and any other tick increments it. The overflow flag sets only on an increment from 0xFF to 0x00.
- R6: With `wave_mode_i` 1 (up/down), the direction turns down on a tick at 0xFF and turns up on a tick at 0x00, and the count moves one step in the new direction. Every tick taken at 0x00 sets the overflow flag.
- R7: A cycle with `host_wr_i` high loads `host_wdata_i` into the count. No count or clear step takes place and the overflow flag is not set, even if a tick is present.
- R8: A host load works with `clk_sel_i` = 0, and `count_o` always shows the current count.
- R9: `bottom_o` is high exactly when the count is 0x00. `top_o` equals `cmp_match_a_i` in mode 2, and in every other mode it is high exactly when the count is 0xFF.
- R10: The overflow flag clears on a cycle with `flag_clr_i` or `irq_ack_i` high. If a set happens in the same cycle, the set wins.
- R11: `dir_down_o` shows the direction bit. Outside mode 1 the direction bit is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 3 | Tick source select |
| presc_tick_i | input | 5 | Prescaled tick strobes (/1, /8, /64, /256, /1024) |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| wave_mode_i | input | 3 | Waveform mode code |
| cmp_match_a_i | input | 1 | A-channel compare match from the compare unit |
| host_wr_i | input | 1 | Host load strobe for the count |
| host_wdata_i | input | 8 | Host load value |
| flag_clr_i | input | 1 | Host write-one-to-clear of the overflow flag |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse; clears the overflow flag |
| count_o | output | 8 | Current count |
| top_o | output | 1 | Count at the mode's maximum |
| bottom_o | output | 1 | Count at zero |
| dir_down_o | output | 1 | Current counting direction (1 = down) |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is the turn at the bottom in up/down mode. The direction bit can only become "down" after the counter climbs to 0xFF, and the flag must stay clear while the count is still falling. The bench loads 0xFD, steps through the turn at the top, then loads 0x02 while the direction is still down. This walks the count onto zero and checks the overflow set and the direction flip on that single tick. The collision between a flag set and a host clear is forced the same way: a load parks the count at 0xFF, and the clear is driven in the same cycle as the wrapping tick.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    localparam int SEL_W  = 3;
    localparam int MODE_W = 3;
    localparam int N_PRE  = 5;

    typedef enum logic [SEL_W-1:0] {
        CS_STOP     = 3'd0,
        CS_P1       = 3'd1,
        CS_P8       = 3'd2,
        CS_P64      = 3'd3,
        CS_P256     = 3'd4,
        CS_P1024    = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    localparam logic [MODE_W-1:0] WM_WRAP  = 3'd0;
    localparam logic [MODE_W-1:0] WM_PHASE = 3'd1;
    localparam logic [MODE_W-1:0] WM_CLR   = 3'd2;

    typedef enum logic [1:0] {
        K_WRAP,
        K_PHASE,
        K_CLR
    } seq_kind_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_DEC,
        ACT_CLR
    } cnt_act_e;

    typedef struct packed {
        cnt_act_e act;
        logic     dir_dn;
        logic     ovf_set;
    } seq_dec_t;

    function automatic seq_kind_e decode_mode(logic [MODE_W-1:0] m);
        case (m)
            WM_PHASE: return K_PHASE;
            WM_CLR:   return K_CLR;
            default:  return K_WRAP;
        endcase
    endfunction

endpackage

// File: rtl/updn_tmr_tick_sel.sv
module updn_tmr_tick_sel
    import updn_tmr_pkg::*;
#(
    parameter int NPRE = N_PRE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NPRE-1:0]  presc_i,
    input  logic             ext_i,
    output logic             tick_o
);
    localparam int NSRC = 1 << SEL_W;

    logic [1:0]      sync_q;
    logic            prev_q;
    logic            ext_rise;
    logic            ext_fall;
    logic [NSRC-1:0] src;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_i};
            prev_q <= sync_q[1];
        end
    end

    assign ext_rise = sync_q[1] & ~prev_q;
    assign ext_fall = ~sync_q[1] & prev_q;

    assign src[CS_STOP]     = 1'b0;
    assign src[CS_EXT_FALL] = ext_fall;
    assign src[CS_EXT_RISE] = ext_rise;

    for (genvar g = 1; g <= 5; g++) begin : g_pre
        if (g <= NPRE) begin : g_on
            assign src[g] = presc_i[g-1];
        end else begin : g_off
            assign src[g] = 1'b0;
        end
    end

    assign tick_o = src[sel_i];

endmodule

// File: rtl/updn_tmr_seq.sv
module updn_tmr_seq
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              match_a_i,
    input  logic              host_wr_i,
    input  logic [CNT_W-1:0]  host_wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              dir_dn_o,
    output logic              top_o,
    output logic              bottom_o,
    output logic              ovf_evt_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             at_max;
    logic             at_zero;
    seq_kind_e        kind;
    seq_dec_t         dec;

    assign kind    = decode_mode(mode_i);
    assign at_max  = (cnt_q == MAXV);
    assign at_zero = (cnt_q == '0);

    always_comb begin
        dec.act     = ACT_HOLD;
        dec.dir_dn  = (kind == K_PHASE) ? dir_q : 1'b0;
        dec.ovf_set = 1'b0;
        if (tick_i && !host_wr_i) begin
            case (kind)
                K_CLR: begin
                    if (match_a_i) begin
                        dec.act = ACT_CLR;
                    end else begin
                        dec.act     = ACT_INC;
                        dec.ovf_set = at_max;
                    end
                end
                K_PHASE: begin
                    if (at_max)       dec.dir_dn = 1'b1;
                    else if (at_zero) dec.dir_dn = 1'b0;
                    dec.act     = dec.dir_dn ? ACT_DEC : ACT_INC;
                    dec.ovf_set = at_zero;
                end
                default: begin
                    dec.act     = ACT_INC;
                    dec.ovf_set = at_max;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            dir_q <= dec.dir_dn;
            if (host_wr_i) begin
                cnt_q <= host_wdata_i;
            end else begin
                case (dec.act)
                    ACT_INC: cnt_q <= cnt_q + ONE;
                    ACT_DEC: cnt_q <= cnt_q - ONE;
                    ACT_CLR: cnt_q <= '0;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    assign count_o   = cnt_q;
    assign dir_dn_o  = dir_q;
    assign bottom_o  = at_zero;
    assign top_o     = (kind == K_CLR) ? match_a_i : at_max;
    assign ovf_evt_o = dec.ovf_set;

endmodule

// File: rtl/updn_tmr_flag.sv
module updn_tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_wr_i,
    input  logic ack_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)                     flag_q <= 1'b0;
        else if (set_i)              flag_q <= 1'b1;
        else if (clr_wr_i || ack_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/updn_tmr_core.sv
module updn_tmr_core
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NPRE  = N_PRE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  clk_sel_i,
    input  logic [NPRE-1:0]   presc_tick_i,
    input  logic              ext_pin_i,
    input  logic [MODE_W-1:0] wave_mode_i,
    input  logic              cmp_match_a_i,
    input  logic              host_wr_i,
    input  logic [CNT_W-1:0]  host_wdata_i,
    input  logic              flag_clr_i,
    input  logic              irq_ack_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              top_o,
    output logic              bottom_o,
    output logic              dir_down_o,
    output logic              ovf_flag_o
);
    logic tick;
    logic ovf_evt;

    updn_tmr_tick_sel #(.NPRE(NPRE)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (clk_sel_i),
        .presc_i (presc_tick_i),
        .ext_i   (ext_pin_i),
        .tick_o  (tick)
    );

    updn_tmr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .mode_i       (wave_mode_i),
        .match_a_i    (cmp_match_a_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .count_o      (count_o),
        .dir_dn_o     (dir_down_o),
        .top_o        (top_o),
        .bottom_o     (bottom_o),
        .ovf_evt_o    (ovf_evt)
    );

    updn_tmr_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_i    (ovf_evt),
        .clr_wr_i (flag_clr_i),
        .ack_i    (irq_ack_i),
        .flag_o   (ovf_flag_o)
    );

endmodule

// File: rtl/updn_tmr_chk.sv
module updn_tmr_chk
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  clk_sel_i,
    input logic [MODE_W-1:0] wave_mode_i,
    input logic              host_wr_i,
    input logic [CNT_W-1:0]  host_wdata_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              ovf_flag_o,
    input logic              dir_down_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !ovf_flag_o && !dir_down_o));

    a_r7_host_load: assert property (@(posedge clk) disable iff (rst)
        host_wr_i |=> (count_o == $past(host_wdata_i)));

    a_r2_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (clk_sel_i == CS_STOP && !host_wr_i) |=> $stable(count_o));

    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (!host_wr_i && wave_mode_i == WM_WRAP && count_o == MAXV) ##1 (count_o == '0)
        |-> ovf_flag_o);

    a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
        (wave_mode_i == WM_PHASE && !host_wr_i) |=>
        (count_o == $past(count_o) || count_o == $past(count_o) + ONE ||
         count_o == $past(count_o) - ONE));

    a_r11_dir_idle: assert property (@(posedge clk) disable iff (rst)
        (wave_mode_i != WM_PHASE) |=> !dir_down_o);

endmodule

bind updn_tmr_core updn_tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_sel_i    (clk_sel_i),
    .wave_mode_i  (wave_mode_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .count_o      (count_o),
    .ovf_flag_o   (ovf_flag_o),
    .dir_down_o   (dir_down_o)
);

// File: tb/updn_tmr_core_tb.sv
module updn_tmr_core_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] clk_sel;
    logic [4:0] presc;
    logic       ext_pin;
    logic [2:0] wmode;
    logic       match_a;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic       flag_clr;
    logic       irq_ack;
    logic [7:0] count;
    logic       top;
    logic       bottom;
    logic       dir_dn;
    logic       ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    updn_tmr_core u_dut (
        .clk           (clk),
        .rst           (rst),
        .clk_sel_i     (clk_sel),
        .presc_tick_i  (presc),
        .ext_pin_i     (ext_pin),
        .wave_mode_i   (wmode),
        .cmp_match_a_i (match_a),
        .host_wr_i     (host_wr),
        .host_wdata_i  (host_wdata),
        .flag_clr_i    (flag_clr),
        .irq_ack_i     (irq_ack),
        .count_o       (count),
        .top_o         (top),
        .bottom_o      (bottom),
        .dir_down_o    (dir_dn),
        .ovf_flag_o    (ovf)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load(logic [7:0] v);
        host_wr = 1'b1; host_wdata = v;
        cyc();
        host_wr = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
    endtask

    task automatic run(int n);
        clk_sel = 3'd1; presc = 5'b00001;
        cyc(n);
        clk_sel = 3'd0; presc = 5'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        check("R1 count", count, 0);
        check("R1 flag", ovf, 0);
        check("R1 dir", dir_dn, 0);
        check("R9 bottom at zero", bottom, 1);
    endtask

    task automatic t_select();
        wmode = 3'd0;
        load(8'h3C);
        check("R8 load while stopped", count, 8'h3C);
        presc = 5'b11111;
        cyc(4);
        check("R2 stopped holds", count, 8'h3C);
        clk_sel = 3'd3; presc = 5'b11011;
        cyc(3);
        check("R2 other strobes ignored", count, 8'h3C);
        presc = 5'b00100;
        cyc();
        presc = 5'b0;
        cyc(2);
        check("R2 selected strobe counts", count, 8'h3D);
        clk_sel = 3'd0;
    endtask

    task automatic t_ext();
        int c0;
        ext_pin = 1'b0; clk_sel = 3'd7;
        cyc(4);
        c0 = count;
        ext_pin = 1'b1; cyc(5);
        check("R3 rising edge counts once", count, c0 + 1);
        ext_pin = 1'b0; cyc(5);
        check("R3 falling ignored in rising mode", count, c0 + 1);
        clk_sel = 3'd6;
        ext_pin = 1'b1; cyc(5);
        check("R3 rising ignored in falling mode", count, c0 + 1);
        ext_pin = 1'b0; cyc(5);
        check("R3 falling edge counts once", count, c0 + 2);
        clk_sel = 3'd0;
    endtask

    task automatic t_wrap();
        wmode = 3'd5;
        load(8'hFE);
        clr_flag();
        run(1);
        check("R4 increment", count, 8'hFF);
        check("R9 top at max", top, 1);
        check("R4 no flag before wrap", ovf, 0);
        run(1);
        check("R4 wrap to zero", count, 0);
        check("R4 wrap sets flag", ovf, 1);
        wmode = 3'd0;
    endtask

    task automatic t_clr_match();
        wmode = 3'd2;
        load(8'h10);
        clr_flag();
        run(3);
        check("R5 increments without match", count, 8'h13);
        match_a = 1'b1;
        #0.1;
        check("R9 top follows match in mode 2", top, 1);
        run(1);
        match_a = 1'b0;
        check("R5 match clears", count, 0);
        check("R5 clear leaves flag", ovf, 0);
        load(8'hFF);
        check("R9 top low at max in mode 2", top, 0);
        run(1);
        check("R5 wrap sets flag", ovf, 1);
        wmode = 3'd0;
    endtask

    task automatic t_phase();
        wmode = 3'd1;
        load(8'hFD);
        clr_flag();
        run(1); check("R6 up step", count, 8'hFE);
        run(1); check("R6 reach max", count, 8'hFF);
        check("R11 still up", dir_dn, 0);
        run(1); check("R6 turn at max", count, 8'hFE);
        check("R11 dir down", dir_dn, 1);
        run(1); check("R6 down step", count, 8'hFD);
        load(8'h02);
        check("R7 load keeps dir", dir_dn, 1);
        run(2); check("R6 reach zero", count, 0);
        check("R6 no flag before bottom tick", ovf, 0);
        run(1); check("R6 turn at zero", count, 1);
        check("R6 bottom tick sets flag", ovf, 1);
        check("R11 dir up again", dir_dn, 0);
        run(1); check("R6 rising after turn", count, 2);
        run(252); check("R6 climb to max", count, 8'hFE);
        run(2); check("R6 dir forced check", dir_dn, 1);
        wmode = 3'd0;
        cyc();
        check("R11 dir cleared outside mode 1", dir_dn, 0);
    endtask

    task automatic t_priority();
        wmode = 3'd0;
        load(8'h40);
        clk_sel = 3'd1; presc = 5'b00001;
        host_wr = 1'b1; host_wdata = 8'h55;
        cyc();
        host_wr = 1'b0;
        check("R7 load beats tick", count, 8'h55);
        cyc();
        check("R7 counting resumes", count, 8'h56);
        clk_sel = 3'd0; presc = 5'b0;
        load(8'hFF);
        clr_flag();
        clk_sel = 3'd1; presc = 5'b00001;
        host_wr = 1'b1; host_wdata = 8'h20;
        cyc();
        host_wr = 1'b0; clk_sel = 3'd0; presc = 5'b0;
        check("R7 load at max", count, 8'h20);
        check("R7 no flag on load cycle", ovf, 0);
    endtask

    task automatic t_flag();
        wmode = 3'd0;
        load(8'hFF);
        run(1);
        check("R10 flag set", ovf, 1);
        clr_flag();
        check("R10 write-one clears", ovf, 0);
        load(8'hFF);
        run(1);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        check("R10 ack clears", ovf, 0);
        load(8'hFF);
        flag_clr = 1'b1;
        run(1);
        flag_clr = 1'b0;
        check("R10 set wins over clear", ovf, 1);
    endtask

    initial begin
        rst = 1'b1; clk_sel = 3'd0; presc = 5'b0; ext_pin = 1'b0;
        wmode = 3'd0; match_a = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
        flag_clr = 1'b0; irq_ack = 1'b0;
        cyc();
        t_reset();
        t_select();
        t_ext();
        t_wrap();
        t_clr_match();
        t_phase();
        t_priority();
        t_flag();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule